// File: doc/BRIEF.md
# Serial Register Port with Selectable Bit Order

This block is a slave serial control port. A host processor uses it to read and write a bank of eight 8-bit control registers. The host drives an active-low select, a serial clock and a data line into the port. The port answers on a data output that carries a separate enable flag. A static order input chooses how bits travel inside every byte: least significant bit first, or most significant bit first. All serial inputs are resynchronised to the block's own clock, and serial clock edges are detected in that clock domain.

Each select period opens with one command byte. Every later byte in the same period is a data byte. The command byte holds a direction bit and a register address. On a write, each complete data byte goes into the addressed register. On a read, the addressed register is shifted out again during every data byte. Every register is also available in parallel on a flat output bus, so the surrounding logic can use it.

Top module: `mcu_reg_port`

## Requirements
- R1: After reset, every register reads 0x00 on the parallel bus, `sdoEn` is low and `sdo` is 0.
- R2: With `lsbFirst`=1, a frame made of a write command and one data byte stores that byte in the addressed register. Each byte's bit 0 travels first, and input bits are taken on rising serial clock edges.
- R3: With `lsbFirst`=0, the same write frame stores the byte when each byte's bit 7 travels first.
- R4: Command byte layout: bit 7 set means read and clear means write, bits 2:0 hold the register address, and bits 6:3 are ignored.
- R5: The address does not advance within a frame. Several data bytes in one write frame all land in the same register, the last one remains, and the neighbouring registers stay unchanged.
- R6: On a read, the addressed register is sent on `sdo` during every data byte of the frame, in the selected bit order. Output bits change after falling serial clock edges and are valid when the next rising edge arrives.
- R7: `sdoEn` is high only during the data bytes of a read frame. While select is high, and throughout a write frame, `sdoEn` is low and `sdo` is 0.
- R8: If select is raised before a byte is complete, that partial byte is dropped and leaves no register changed. The next frame is decoded from its first bit.
- R9: A frame holds only one command byte. A byte that follows the command inside the same frame is always treated as data, even when it looks like a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, which oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsbFirst | input | 1 | Bit order: 1 sends bit 0 first, 0 sends bit 7 first |
| csN | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host, 0 when not enabled |
| sdoEn | output | 1 | High while `sdo` carries read data |
| regFlat | output | 64 | All registers side by side, register n at bits 8n+7:8n |

## Verification
The checker assumes that the serial clock stays low while select changes, and that each serial clock level lasts several block clocks, so every edge survives the synchroniser as a single detected event. It also assumes that `lsbFirst` changes only between frames. The bench drives every serial pin on falling block-clock edges. It holds each serial clock level for eight block clocks, leaves a settling gap around each select change, and changes the bit order only while select is high.

// File: rtl/mcu_reg_port_pkg.sv
package mcu_reg_port_pkg;

  // Strobes issued by the control path to the datapath, one cycle each.
  typedef struct packed {
    logic shiftIn;   // capture one serial input bit
    logic cmdLatch;  // current byte is the command byte
    logic wrEn;      // write the completed byte to the register file
    logic txLoad;    // load transmit shifter from the register file
    logic txShift;   // present next transmit bit
    logic clearOut;  // select inactive: clear shifters and output bit
  } portStrobes_t;

endpackage

// File: rtl/mcu_reg_port_ctrl.sv
module mcu_reg_port_ctrl
  import mcu_reg_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rxNext,
  output logic              sdiBit,
  output logic              csActive,
  output logic [$clog2(DATA_W)-1:0] bitCnt,
  output logic              isRead,
  output logic              cmdPhase,
  output logic [ADDR_W-1:0] curAddr,
  output logic              sdoEn,
  output portStrobes_t      strb
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam int RW_BIT = DATA_W - 1;

  logic [SYNC_STAGES-1:0] sclkSync, csSync, sdiSync;
  logic                   sclkPrev;
  logic                   sclkNow;
  logic                   sclkRise, sclkFall, byteEnd;
  logic [ADDR_W-1:0]      addrReg;

  // Pin synchronisers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkSync <= '0;
      csSync   <= '1;
      sdiSync  <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdi};
      sclkPrev <= sclkSync[SYNC_STAGES-1];
    end
  end

  assign sclkNow  = sclkSync[SYNC_STAGES-1];
  assign csActive = ~csSync[SYNC_STAGES-1];
  assign sdiBit   = sdiSync[SYNC_STAGES-1];
  assign sclkRise = csActive & sclkNow & ~sclkPrev;
  assign sclkFall = csActive & ~sclkNow & sclkPrev;
  assign byteEnd  = sclkRise && (bitCnt == LAST_BIT);

  // Frame state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      cmdPhase <= 1'b1;
      isRead   <= 1'b0;
      addrReg  <= '0;
    end else if (!csActive) begin
      bitCnt   <= '0;
      cmdPhase <= 1'b1;
      isRead   <= 1'b0;
    end else if (sclkRise) begin
      bitCnt <= bitCnt + 1'b1;
      if (byteEnd && cmdPhase) begin
        cmdPhase <= 1'b0;
        isRead   <= rxNext[RW_BIT];
        addrReg  <= rxNext[ADDR_W-1:0];
      end
    end
  end

  assign curAddr = (cmdPhase && byteEnd) ? rxNext[ADDR_W-1:0] : addrReg;

  always_comb begin
    strb          = '0;
    strb.shiftIn  = sclkRise;
    strb.cmdLatch = byteEnd & cmdPhase;
    strb.wrEn     = byteEnd & ~cmdPhase & ~isRead;
    strb.txLoad   = byteEnd & (cmdPhase ? rxNext[RW_BIT] : isRead);
    strb.txShift  = sclkFall;
    strb.clearOut = ~csActive;
  end

  assign sdoEn = csActive & ~cmdPhase & isRead;

endmodule

// File: rtl/mcu_reg_port_dp.sv
module mcu_reg_port_dp
  import mcu_reg_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lsbFirst,
  input  logic                          sdiBit,
  input  logic [ADDR_W-1:0]             curAddr,
  input  portStrobes_t                  strb,
  output logic [DATA_W-1:0]             rxNext,
  output logic                          sdoReg,
  output logic [(2**ADDR_W)*DATA_W-1:0] regFlat
);

  localparam int NUM_REGS = 2 ** ADDR_W;

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] regBank [NUM_REGS];

  // Receive assembly in the selected order
  always_comb begin
    if (lsbFirst) rxNext = {sdiBit, rxShift[DATA_W-1:1]};
    else          rxNext = {rxShift[DATA_W-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rxShift <= '0;
    else if (strb.clearOut) rxShift <= '0;
    else if (strb.shiftIn)  rxShift <= rxNext;
  end

  // Transmit shifter, output bit updated on falling serial edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '0;
      sdoReg  <= 1'b0;
    end else if (strb.clearOut) begin
      txShift <= '0;
      sdoReg  <= 1'b0;
    end else if (strb.txLoad) begin
      txShift <= regBank[curAddr];
    end else if (strb.txShift) begin
      if (lsbFirst) begin
        sdoReg  <= txShift[0];
        txShift <= txShift >> 1;
      end else begin
        sdoReg  <= txShift[DATA_W-1];
        txShift <= txShift << 1;
      end
    end
  end

  // Register bank
  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regBank[g] <= '0;
      else if (strb.wrEn && (curAddr == ADDR_W'(g)))
        regBank[g] <= rxNext;
    end
    assign regFlat[g*DATA_W +: DATA_W] = regBank[g];
  end

endmodule

// File: rtl/mcu_reg_port.sv
module mcu_reg_port
  import mcu_reg_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lsbFirst,
  input  logic                          csN,
  input  logic                          sclk,
  input  logic                          sdi,
  output logic                          sdo,
  output logic                          sdoEn,
  output logic [(2**ADDR_W)*DATA_W-1:0] regFlat
);

  localparam int CNT_W = $clog2(DATA_W);

  portStrobes_t      strb;
  logic              sdiBit, csActive, isRead, cmdPhase, sdoReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] rxNext;

  mcu_reg_port_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .sdi(sdi),
    .rxNext(rxNext), .sdiBit(sdiBit), .csActive(csActive),
    .bitCnt(bitCnt), .isRead(isRead), .cmdPhase(cmdPhase),
    .curAddr(curAddr), .sdoEn(sdoEn), .strb(strb)
  );

  mcu_reg_port_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .lsbFirst(lsbFirst), .sdiBit(sdiBit),
    .curAddr(curAddr), .strb(strb), .rxNext(rxNext), .sdoReg(sdoReg),
    .regFlat(regFlat)
  );

  assign sdo = sdoEn ? sdoReg : 1'b0;

endmodule

// File: rtl/mcu_reg_port_chk.sv
module mcu_reg_port_chk
  import mcu_reg_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input portStrobes_t                  strb,
  input logic                          csActive,
  input logic [$clog2(DATA_W)-1:0]     bitCnt,
  input logic                          isRead,
  input logic                          sdoEn,
  input logic                          sdoReg,
  input logic [(2**ADDR_W)*DATA_W-1:0] regFlat
);

  // R5: the bank changes only right after a write strobe
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regFlat) |-> $past(strb.wrEn));

  // R8: select going inactive restarts the bit count
  a_r8_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !csActive |=> (bitCnt == '0));

  // R6: the output bit moves only after a falling serial edge or a clear
  a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdoReg) |-> ($past(strb.txShift) || $past(strb.clearOut)));

  // R4: a read frame never writes
  a_r4_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    isRead |-> !strb.wrEn);

  // R7: no write takes place while the output is enabled
  a_r7_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrEn |-> !sdoEn);

  // R9: command capture, data write and output shift never coincide
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.cmdLatch, strb.wrEn, strb.txShift}));

endmodule

bind mcu_reg_port mcu_reg_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb(strb), .csActive(csActive),
  .bitCnt(bitCnt), .isRead(isRead), .sdoEn(sdoEn), .sdoReg(sdoReg),
  .regFlat(regFlat)
);

// File: tb/mcu_reg_port_bench.sv
module mcu_reg_port_bench;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lsbFirst = 1'b1;
  logic        csN = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdoEn;
  logic [63:0] regFlat;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [7:0] txBuf [4];
  logic [7:0] rxBuf [4];
  bit         enSeen;

  always #5 clk = ~clk;

  mcu_reg_port u_mcu_reg_port (
    .clk(clk), .rst_n(rst_n), .lsbFirst(lsbFirst), .csN(csN),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdoEn(sdoEn), .regFlat(regFlat)
  );

  function automatic logic [7:0] getReg(input int a);
    return regFlat[a*8 +: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shiftByte(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      automatic int idx = lsbFirst ? i : 7 - i;
      @(negedge clk); sdi = b[idx];
      repeat (HALF) @(negedge clk);
      got[idx] = sdo;
      if (sdoEn) enSeen = 1;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // Command byte then nData data bytes; partial>0 truncates the last byte
  task automatic frame(input logic [7:0] cmd, input int nData, input int partial);
    logic [7:0] dummy;
    enSeen = 0;
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
    shiftByte(cmd, (nData == 0 && partial > 0) ? partial : 8, dummy);
    for (int k = 0; k < nData; k++)
      shiftByte(txBuf[k], (k == nData - 1 && partial > 0) ? partial : 8, rxBuf[k]);
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic writeReg(input int a, input logic [7:0] d);
    txBuf[0] = d;
    frame(8'(a), 1, 0);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) check("R1 reg", 32'(getReg(a)), 32'h0);
    check("R1 sdoEn", 32'(sdoEn), 32'h0);
    check("R1 sdo", 32'(sdo), 32'h0);
  endtask

  task automatic t_write_lsb();
    lsbFirst = 1'b1;
    writeReg(2, 8'hC4);
    check("R2 reg2", 32'(getReg(2)), 32'hC4);
    writeReg(5, 8'h3C);
    check("R2 reg5", 32'(getReg(5)), 32'h3C);
    check("R7 write silent", 32'(enSeen), 32'h0);
  endtask

  task automatic t_write_msb();
    lsbFirst = 1'b0;
    writeReg(6, 8'h1E);
    check("R3 reg6", 32'(getReg(6)), 32'h1E);
    writeReg(0, 8'h81);
    check("R3 reg0", 32'(getReg(0)), 32'h81);
  endtask

  task automatic t_read();
    lsbFirst = 1'b1;
    txBuf[0] = 8'h00; txBuf[1] = 8'hFF;
    frame(8'h82, 2, 0);
    check("R6 lsb byte0", 32'(rxBuf[0]), 32'hC4);
    check("R6 lsb byte1", 32'(rxBuf[1]), 32'hC4);
    check("R7 read enabled", 32'(enSeen), 32'h1);
    check("R7 idle sdoEn", 32'(sdoEn), 32'h0);
    lsbFirst = 1'b0;
    frame(8'h86, 2, 0);
    check("R6 msb byte0", 32'(rxBuf[0]), 32'h1E);
    check("R6 msb byte1", 32'(rxBuf[1]), 32'h1E);
    check("R6 read no change", 32'(getReg(6)), 32'h1E);
  endtask

  task automatic t_cmd_fields();
    lsbFirst = 1'b1;
    txBuf[0] = 8'h5B;
    frame(8'h79, 1, 0);               // write, junk in bits 6:3, addr 1
    check("R4 write addr1", 32'(getReg(1)), 32'h5B);
    txBuf[0] = 8'h00;
    frame(8'hF9, 1, 0);               // read, junk in bits 6:3, addr 1
    check("R4 read addr1", 32'(rxBuf[0]), 32'h5B);
  endtask

  task automatic t_no_incr();
    lsbFirst = 1'b0;
    txBuf[0] = 8'h11; txBuf[1] = 8'h22; txBuf[2] = 8'h33;
    frame(8'h04, 3, 0);
    check("R5 last byte kept", 32'(getReg(4)), 32'h33);
    check("R5 neighbour", 32'(getReg(5)), 32'h3C);
  endtask

  task automatic t_partial();
    lsbFirst = 1'b1;
    writeReg(3, 8'h5A);
    txBuf[0] = 8'hFF;
    frame(8'h03, 1, 4);
    check("R8 partial data dropped", 32'(getReg(3)), 32'h5A);
    frame(8'h07, 0, 3);
    check("R8 partial cmd harmless", 32'(getReg(7)), 32'h00);
    writeReg(3, 8'h96);
    check("R8 counter restarted", 32'(getReg(3)), 32'h96);
  endtask

  task automatic t_cmd_once();
    lsbFirst = 1'b0;
    txBuf[0] = 8'h82; txBuf[1] = 8'h03;
    frame(8'h01, 2, 0);
    check("R9 data not command", 32'(getReg(1)), 32'h03);
    check("R9 reg2 intact", 32'(getReg(2)), 32'hC4);
    check("R9 no read output", 32'(enSeen), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_write_lsb();
    t_write_msb();
    t_read();
    t_cmd_fields();
    t_no_incr();
    t_partial();
    t_cmd_once();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule